// File: doc/BRIEF.md
# SPI Command Decoder and Buffer Bridge

This block sits behind a byte-wide SPI slave shifter and turns the host's half-duplex command stream into accesses to a local byte buffer. It receives whole bytes with a one-cycle valid strobe and an active-low chip select that frames each command. For every strobe it registers the byte to be shifted out in the following byte slot. Replies therefore always come one slot after the byte that asked for them.

The first byte of a frame is an opcode. Some opcodes are followed by a 16-bit address, sent high byte first. These opcodes either program a write or read length, or open a streaming write or read at that address. The address advances by one for each data byte and wraps inside the buffer. Two single-byte opcodes return a fixed identifier or a sticky error code.

Errors cover unknown opcodes and data slots past the programmed length. The first error is held until the host reads it, and reading it clears it.

Top module: `spi_cmd_bridge`

## Requirements
- R1: After reset the outgoing byte is 00h and the stored error code is 00h. 00h is also the filler byte sent in every slot that carries no reply.
- R2: In the idle state, opcode 01h loads DEVICE_ID as the next outgoing byte. The byte received in that reply slot is not decoded, and its slot returns 00h.
- R3: Opcodes 02h (write length) and 05h (read length) take two further bytes, high byte then low byte. Opcodes 04h and 07h take their 16-bit start address the same way.
- R4: After opcode 04h and its address, each byte is written to the buffer at the current address, and the address then increments. Addresses map to the buffer modulo DEPTH.
- R5: After opcode 07h and its address, the strobe of the address low byte loads the byte at the start address for the next slot. Each later strobe loads the byte at the following address. Once the read length has been delivered, the slot returns 00h. A read length of zero returns 00h at once.
- R6: A write data byte beyond the write length is not stored, and it sets error code E2h.
- R7: A read slot beyond the read length returns 00h and sets error code E3h.
- R8: Any idle-state opcode other than 01h, 02h, 04h, 05h, 07h or 08h returns 00h and sets error code E1h.
- R9: Opcode 08h loads the stored error code as the next outgoing byte and clears it. Its reply slot is treated like the one for 01h. The error code is sticky: while it is non-zero, later errors do not replace it.
- R10: Raising chip select returns the decoder to opcode wait, drops any partial header, and sets the outgoing byte to 00h on the next clock. The programmed lengths are kept.
- R11: Strobes received while chip select is high are ignored: they change neither the buffer nor the outgoing byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select framing a command |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte to shift out in the next byte slot |

## Verification
The bench builds the block with DEPTH = 16 and DEVICE_ID = A5h. With a buffer that small, a short stream starting at address 0Eh crosses the wrap point. The same choice makes a swapped address order visible, because 0E00h would land on entry 0. A prefill of all sixteen entries with known values means that a rejected overrun byte can be seen when the buffer is read back. Length and error corner cases are reached with transfers of a few bytes: zero length, one byte past the limit, and a second error while the first is still pending.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  localparam logic [7:0] OP_ID    = 8'h01;
  localparam logic [7:0] OP_WLEN  = 8'h02;
  localparam logic [7:0] OP_WRITE = 8'h04;
  localparam logic [7:0] OP_RLEN  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h07;
  localparam logic [7:0] OP_ERR   = 8'h08;

  localparam logic [7:0] FILL_BYTE   = 8'h00;
  localparam logic [7:0] ERR_NONE    = 8'h00;
  localparam logic [7:0] ERR_BAD_OP  = 8'hE1;
  localparam logic [7:0] ERR_WR_OVER = 8'hE2;
  localparam logic [7:0] ERR_RD_OVER = 8'hE3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA,
    ST_REPLY
  } dec_state_e;

  typedef enum logic [1:0] {
    K_WLEN,
    K_RLEN,
    K_WRITE,
    K_READ
  } cmd_kind_e;

endpackage

// File: rtl/spi_bridge_mem.sv
module spi_bridge_mem #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/spi_bridge_err.sv
module spi_bridge_err
  import spi_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_en,
  input  logic [7:0] set_code,
  input  logic       clr_en,
  output logic [7:0] err_code
);

  logic [7:0] err_q, err_d;
  logic       err_en;

  always_comb begin
    err_d  = err_q;
    err_en = 1'b0;
    if (set_en && (err_q == ERR_NONE)) begin
      err_d  = set_code;
      err_en = 1'b1;
    end else if (clr_en) begin
      err_d  = ERR_NONE;
      err_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= ERR_NONE;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign err_code = err_q;

endmodule

// File: rtl/spi_bridge_ctrl.sv
module spi_bridge_ctrl
  import spi_bridge_pkg::*;
#(
  parameter logic [7:0] DEVICE_ID = 8'h5A,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic [7:0]    tx_byte,
  output logic          in_idle,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          err_set,
  output logic [7:0]    err_set_code,
  output logic          err_clr,
  input  logic [7:0]    err_code
);

  dec_state_e st_q, st_d;
  cmd_kind_e  kind_q, kind_d;
  logic [15:0] addr_q, addr_d;
  logic [15:0] cnt_q, cnt_d;
  logic [15:0] wlen_q, wlen_d;
  logic [15:0] rlen_q, rlen_d;
  logic [7:0]  tx_q, tx_d;
  logic        step, reg_en;
  logic [15:0] rd_full;
  logic [15:0] hdr_addr;
  logic        rd_more;

  assign step     = !cs_n && rx_valid;
  assign reg_en   = cs_n || rx_valid;
  assign hdr_addr = {addr_q[15:8], rx_byte};
  assign rd_full  = (st_q == ST_ALO) ? hdr_addr : (addr_q + 16'd1);
  assign rd_addr  = rd_full[AW-1:0];
  assign wr_addr  = addr_q[AW-1:0];
  assign wr_data  = rx_byte;
  assign rd_more  = ({1'b0, cnt_q} + 17'd1) < {1'b0, rlen_q};

  always_comb begin
    st_d         = st_q;
    kind_d       = kind_q;
    addr_d       = addr_q;
    cnt_d        = cnt_q;
    wlen_d       = wlen_q;
    rlen_d       = rlen_q;
    tx_d         = tx_q;
    wr_en        = 1'b0;
    err_set      = 1'b0;
    err_set_code = ERR_NONE;
    err_clr      = 1'b0;
    if (cs_n) begin
      st_d = ST_IDLE;
      tx_d = FILL_BYTE;
    end else if (step) begin
      tx_d = FILL_BYTE;
      unique case (st_q)
        ST_IDLE: begin
          unique case (rx_byte)
            OP_ID: begin
              tx_d = DEVICE_ID;
              st_d = ST_REPLY;
            end
            OP_ERR: begin
              tx_d    = err_code;
              err_clr = 1'b1;
              st_d    = ST_REPLY;
            end
            OP_WLEN: begin
              kind_d = K_WLEN;
              st_d   = ST_AHI;
            end
            OP_RLEN: begin
              kind_d = K_RLEN;
              st_d   = ST_AHI;
            end
            OP_WRITE: begin
              kind_d = K_WRITE;
              st_d   = ST_AHI;
            end
            OP_READ: begin
              kind_d = K_READ;
              st_d   = ST_AHI;
            end
            default: begin
              err_set      = 1'b1;
              err_set_code = ERR_BAD_OP;
            end
          endcase
        end
        ST_AHI: begin
          addr_d[15:8] = rx_byte;
          st_d         = ST_ALO;
        end
        ST_ALO: begin
          unique case (kind_q)
            K_WLEN: begin
              wlen_d = hdr_addr;
              st_d   = ST_IDLE;
            end
            K_RLEN: begin
              rlen_d = hdr_addr;
              st_d   = ST_IDLE;
            end
            K_WRITE: begin
              addr_d = hdr_addr;
              cnt_d  = 16'd0;
              st_d   = ST_WDATA;
            end
            K_READ: begin
              addr_d = hdr_addr;
              cnt_d  = 16'd0;
              st_d   = ST_RDATA;
              tx_d   = (rlen_q != 16'd0) ? rd_data : FILL_BYTE;
            end
            default: st_d = ST_IDLE;
          endcase
        end
        ST_WDATA: begin
          if (cnt_q < wlen_q) begin
            wr_en  = 1'b1;
            addr_d = addr_q + 16'd1;
            cnt_d  = cnt_q + 16'd1;
          end else begin
            err_set      = 1'b1;
            err_set_code = ERR_WR_OVER;
          end
        end
        ST_RDATA: begin
          if (cnt_q < rlen_q) begin
            addr_d = addr_q + 16'd1;
            cnt_d  = cnt_q + 16'd1;
            tx_d   = rd_more ? rd_data : FILL_BYTE;
          end else begin
            err_set      = 1'b1;
            err_set_code = ERR_RD_OVER;
          end
        end
        ST_REPLY: st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_WLEN;
      addr_q <= 16'd0;
      cnt_q  <= 16'd0;
      wlen_q <= 16'd0;
      rlen_q <= 16'd0;
      tx_q   <= FILL_BYTE;
    end else if (reg_en) begin
      st_q   <= st_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      wlen_q <= wlen_d;
      rlen_q <= rlen_d;
      tx_q   <= tx_d;
    end
  end

  assign tx_byte = tx_q;
  assign in_idle = (st_q == ST_IDLE);

endmodule

// File: rtl/spi_cmd_bridge.sv
module spi_cmd_bridge
  import spi_bridge_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter logic [7:0] DEVICE_ID = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic [7:0] tx_byte
);

  localparam int AW = $clog2(DEPTH);

  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  logic          in_idle;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          err_set;
  logic [7:0]    err_set_code;
  logic          err_clr;
  logic [7:0]    err_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  spi_bridge_ctrl #(
    .DEVICE_ID(DEVICE_ID),
    .AW(AW)
  ) u_ctrl (
    .clk(clk),
    .rst_n(rst_sync_n),
    .cs_n(cs_n),
    .rx_valid(rx_valid),
    .rx_byte(rx_byte),
    .tx_byte(tx_byte),
    .in_idle(in_idle),
    .wr_en(wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .err_set(err_set),
    .err_set_code(err_set_code),
    .err_clr(err_clr),
    .err_code(err_code)
  );

  spi_bridge_mem #(
    .DEPTH(DEPTH)
  ) u_mem (
    .clk(clk),
    .wr_en(wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  spi_bridge_err u_err (
    .clk(clk),
    .rst_n(rst_sync_n),
    .set_en(err_set),
    .set_code(err_set_code),
    .clr_en(err_clr),
    .err_code(err_code)
  );

endmodule

// File: rtl/spi_cmd_bridge_chk.sv
module spi_cmd_bridge_chk #(
  parameter logic [7:0] DEVICE_ID = 8'h5A
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic [7:0] tx_byte,
  input logic       in_idle,
  input logic       wr_en,
  input logic       err_clr,
  input logic [7:0] err_code
);

  logic known_op;
  assign known_op = (rx_byte == 8'h01) || (rx_byte == 8'h02) || (rx_byte == 8'h04) ||
                    (rx_byte == 8'h05) || (rx_byte == 8'h07) || (rx_byte == 8'h08);

  AST_ID_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rx_valid && in_idle && rx_byte == 8'h01) |=> (tx_byte == DEVICE_ID)); // R2

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rx_valid) |=> $stable(tx_byte)); // R5

  AST_BAD_OP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rx_valid && in_idle && !known_op) |=> (err_code != 8'h00)); // R8

  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (err_code == 8'h00)); // R9

  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (in_idle && tx_byte == 8'h00)); // R10

  AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !wr_en); // R11

endmodule

bind spi_cmd_bridge spi_cmd_bridge_chk #(
  .DEVICE_ID(DEVICE_ID)
) u_chk (
  .clk(clk),
  .rst_n(rst_sync_n),
  .cs_n(cs_n),
  .rx_valid(rx_valid),
  .rx_byte(rx_byte),
  .tx_byte(tx_byte),
  .in_idle(in_idle),
  .wr_en(wr_en),
  .err_clr(err_clr),
  .err_code(err_code)
);

// File: tb/sim_spi_cmd_bridge.sv
module sim_spi_cmd_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam logic [7:0] DEV_ID = 8'hA5;

  logic       clk;
  logic       rst_n;
  logic       cs_n;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic [7:0] tx_byte;

  int checks;
  int errors;
  bit done;

  spi_cmd_bridge #(
    .DEPTH(DEPTH),
    .DEVICE_ID(DEV_ID)
  ) u0 (
    .clk(clk),
    .rst_n(rst_n),
    .cs_n(cs_n),
    .rx_valid(rx_valid),
    .rx_byte(rx_byte),
    .tx_byte(tx_byte)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, output logic [7:0] got);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    got      = tx_byte;
  endtask

  task automatic send_nochk(input logic [7:0] b);
    logic [7:0] dummy;
    send(b, dummy);
  endtask

  task automatic frame_on();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic frame_off();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] g;
    chk("R1 reset tx", tx_byte, 8'h00);
    frame_on();
    send(8'h08, g); chk("R1 error code after reset", g, 8'h00);
    send(8'h00, g); chk("R1 filler in reply slot", g, 8'h00);
    frame_off();
  endtask

  task automatic t_id();
    logic [7:0] g;
    frame_on();
    send(8'h01, g); chk("R2 device id", g, DEV_ID);
    send(8'h01, g); chk("R2 reply slot not decoded", g, 8'h00);
    send(8'h01, g); chk("R2 device id again", g, DEV_ID);
    send(8'h00, g);
    frame_off();
  endtask

  task automatic t_prefill();
    frame_on();
    send_nochk(8'h02); send_nochk(8'h00); send_nochk(8'h10);
    send_nochk(8'h04); send_nochk(8'h00); send_nochk(8'h00);
    for (int i = 0; i < DEPTH; i++) send_nochk(8'h80 + 8'(i));
    frame_off();
  endtask

  task automatic t_stream();
    logic [7:0] g;
    logic [7:0] exp_rd [7];
    exp_rd = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h82, 8'h83, 8'h00};
    frame_on();
    send_nochk(8'h02); send_nochk(8'h00); send_nochk(8'h04);
    send_nochk(8'h04); send_nochk(8'h00); send_nochk(8'h0E);
    send_nochk(8'h11); send_nochk(8'h22); send_nochk(8'h33); send_nochk(8'h44);
    send_nochk(8'h55);
    frame_off();
    frame_on();
    send_nochk(8'h05); send_nochk(8'h00); send_nochk(8'h06);
    send_nochk(8'h07); send_nochk(8'h00);
    send(8'h0E, g); chk("R3 R5 first read byte", g, exp_rd[0]);
    for (int i = 1; i < 7; i++) begin
      send(8'h00, g);
      chk($sformatf("R4 R5 R6 read slot %0d", i), g, exp_rd[i]);
    end
    frame_off();
    frame_on();
    send(8'h08, g); chk("R6 write overrun code", g, 8'hE2);
    send(8'h00, g);
    send(8'h08, g); chk("R9 cleared after read", g, 8'h00);
    send(8'h00, g);
    frame_off();
  endtask

  task automatic t_rd_over();
    logic [7:0] g;
    frame_on();
    send_nochk(8'h05); send_nochk(8'h00); send_nochk(8'h01);
    send_nochk(8'h07); send_nochk(8'h00);
    send(8'h05, g); chk("R5 single read", g, 8'h85);
    send(8'h00, g); chk("R5 filler after length", g, 8'h00);
    send(8'h00, g); chk("R7 overrun slot filler", g, 8'h00);
    frame_off();
    frame_on();
    send(8'h08, g); chk("R7 read overrun code", g, 8'hE3);
    send(8'h00, g);
    frame_off();
  endtask

  task automatic t_unknown();
    logic [7:0] g;
    frame_on();
    send(8'h03, g); chk("R8 unknown opcode filler", g, 8'h00);
    send_nochk(8'h05); send_nochk(8'h00); send_nochk(8'h00);
    send_nochk(8'h07); send_nochk(8'h00);
    send(8'h00, g); chk("R5 zero length read", g, 8'h00);
    send(8'h00, g);
    frame_off();
    frame_on();
    send(8'h08, g); chk("R8 R9 first error kept", g, 8'hE1);
    send(8'h00, g);
    send(8'h08, g); chk("R9 cleared", g, 8'h00);
    send(8'h00, g);
    frame_off();
  endtask

  task automatic t_cs();
    logic [7:0] g;
    frame_on();
    send(8'h01, g); chk("R2 id before deselect", g, DEV_ID);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk("R10 tx filler after deselect", tx_byte, 8'h00);
    send(8'h01, g); chk("R11 strobe ignored while deselected", g, 8'h00);
    frame_on();
    send_nochk(8'h04); send_nochk(8'h00);
    frame_off();
    send_nochk(8'h99);
    frame_on();
    send(8'h01, g); chk("R10 partial header dropped", g, DEV_ID);
    send(8'h00, g);
    frame_off();
    frame_on();
    send_nochk(8'h05); send_nochk(8'h00); send_nochk(8'h01);
    send_nochk(8'h07); send_nochk(8'h00);
    send(8'h00, g); chk("R11 buffer untouched while deselected", g, 8'h33);
    frame_off();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks   = 0;
    errors   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    cs_n     = 1'b1;
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_id();
    t_prefill();
    t_stream();
    t_rd_over();
    t_unknown();
    t_cs();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule